// File: doc/BRIEF.md
# LIN transceiver mode controller

This block is the digital mode sequencer for a single-wire LIN physical-layer front end. It watches the synchronized enable and transmit-data lines from the host controller, plus a filtered wake-event pulse from the analog side. From them it decides which of six modes the transceiver is in: Sleep, Awake, Normal, Wait Slow, Slow or Fast. For each mode it drives the controls of the analog front end: the inhibit output that gates an external regulator, the bus driver enable and its slew code, the choice between the weak sleep current source and the resistive pull-up, and what the receive output shows.

The data rate is picked once, at the enable rising edge that wakes the transceiver, from the level of the transmit line at that moment. It then stays locked until the next sleep. Fast mode is a temporary override for production test and download. A short timed handshake on the enable and transmit lines enters it. The same handshake, or a brief low pulse on enable, leaves it again and returns to the locked rate. All time windows are counted in microseconds. A per-timer prescaler derived from the system clock frequency parameter produces those microseconds.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset the mode is Awake (mode code 1). In Awake INH is high, the resistive pull-up is selected, the driver is off, and the receive control is forced low (code 1).
- R2: In Sleep (code 0) or Awake, a rising edge on enable selects Normal (code 2) when transmit data is high. It selects Wait Slow (code 3) when transmit data is low.
- R3: In Wait Slow the driver is off, the receive control is forced high (code 2) and the slew code is slow (0). The first cycle with transmit data high moves the mode to Slow (code 4) on the next clock.
- R4: Once Normal is selected, the mode never moves to Slow or Wait Slow without passing through Sleep. Once Slow or Wait Slow is selected, it never moves to Normal without passing through Sleep. An enable low-then-high with transmit data high does not reselect the rate.
- R5: In Normal, Slow or Fast, the mode becomes Sleep once enable has been low for SLEEP_US microseconds, provided transmit data was high when enable fell. If enable returns high earlier, the mode is unchanged and the delay restarts at the next fall.
- R6: In Sleep, INH is low, the driver is off, the weak current source is selected (pull-up select 0) and the receive control is high impedance (code 0). In every other mode INH is high and the resistive pull-up is selected (pull-up select 1).
- R7: From Normal or Slow, Fast mode (code 5) is entered at an enable rising edge when three conditions hold: enable and transmit data were both low, transmit data then went high, and the rising edge came less than TOGGLE_US microseconds after the first cycle in which both were low. A sequence that takes longer leaves the mode unchanged.
- R8: Fast mode returns to the rate locked at wake-up (Normal or Slow) on a repeat of the entry sequence. It also returns on an enable low pulse shorter than GLITCH_US microseconds.
- R9: In Normal, Slow and Fast the driver is enabled. The dominant request equals the inverse of transmit data, and the receive control is follow-bus (code 3). The slew code is 1 in Normal, 0 in Slow and 2 in Fast.
- R10: In Normal or Slow, an enable low pulse shorter than GLITCH_US microseconds changes nothing. So does a longer low with transmit data low that is not a valid fast sequence.
- R11: In Sleep, a wake-event pulse moves the mode to Awake on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock of CLK_HZ hertz |
| rst_ni | input | 1 | Active-low reset, asynchronous |
| en_i | input | 1 | Synchronized enable from the host |
| txd_i | input | 1 | Synchronized transmit data from the host |
| wake_i | input | 1 | One-cycle filtered wake event (bus or local pin) |
| mode_o | output | 3 | Current mode code |
| inh_o | output | 1 | Inhibit output enable |
| drv_en_o | output | 1 | Bus driver enabled |
| drv_dom_o | output | 1 | Driver pulls the bus dominant |
| slew_o | output | 2 | Slew code: 0 slow, 1 normal, 2 fast |
| pullup_res_o | output | 1 | 1 resistive pull-up, 0 weak current source |
| rxd_ctl_o | output | 2 | Receive control: 0 high-Z, 1 low, 2 high, 3 follow bus |

## Verification
The hardest situations to reach are the timing boundaries. One is the fast-mode handshake, which must count from the first both-low cycle and not from the enable fall. Another is the sleep delay, which must not expire a few cycles early. The stimulus builds each handshake on the clock, so that one variant ends well inside the window and another just past it. The sleep case is sampled once a few microseconds before the delay ends and once just after. The rate lock is reached by first waking into Slow through Wait Slow. A handshake that misses the fast window is then replayed with transmit data high at the enable edge, which must not reselect Normal.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

  typedef enum logic [2:0] {
    M_SLEEP    = 3'd0,
    M_AWAKE    = 3'd1,
    M_NORMAL   = 3'd2,
    M_WAITSLOW = 3'd3,
    M_SLOW     = 3'd4,
    M_FAST     = 3'd5
  } lin_mode_e;

  typedef enum logic [1:0] {
    SLEW_SLOW = 2'd0,
    SLEW_NORM = 2'd1,
    SLEW_FAST = 2'd2
  } slew_e;

  typedef enum logic [1:0] {
    RXC_HIZ  = 2'd0,
    RXC_LOW  = 2'd1,
    RXC_HIGH = 2'd2,
    RXC_BUS  = 2'd3
  } rxd_ctl_e;

  // clock cycles in one microsecond, never below one
  function automatic int unsigned cycles_per_us(int unsigned hz);
    return (hz >= 32'd2_000_000) ? hz / 32'd1_000_000 : 32'd1;
  endfunction

  function automatic logic mode_drives(lin_mode_e m);
    return (m == M_NORMAL) || (m == M_SLOW) || (m == M_FAST);
  endfunction

  function automatic slew_e mode_slew(lin_mode_e m);
    case (m)
      M_SLOW, M_WAITSLOW: return SLEW_SLOW;
      M_FAST:             return SLEW_FAST;
      default:            return SLEW_NORM;
    endcase
  endfunction

  function automatic rxd_ctl_e mode_rxd(lin_mode_e m);
    case (m)
      M_SLEEP:    return RXC_HIZ;
      M_AWAKE:    return RXC_LOW;
      M_WAITSLOW: return RXC_HIGH;
      default:    return RXC_BUS;
    endcase
  endfunction

endpackage

// File: rtl/lin_us_timer.sv
module lin_us_timer #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned MAX_US = 63,
  localparam int unsigned CW    = $clog2(MAX_US + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  output logic [CW-1:0] us_o
);
  import lin_mode_pkg::*;

  localparam int unsigned DIV = cycles_per_us(CLK_HZ);
  localparam int unsigned DW  = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;
  logic          us_strobe;

  assign us_strobe = (div_q == DW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      us_o  <= '0;
    end else if (clr_i) begin
      div_q <= '0;
      us_o  <= '0;
    end else if (run_i) begin
      if (us_strobe) begin
        div_q <= '0;
        if (us_o != CW'(MAX_US)) us_o <= us_o + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R5: elapsed time only grows until cleared
  p_timer_monotone_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (us_o >= $past(us_o)));

endmodule

// File: rtl/lin_toggle_detect.sv
module lin_toggle_detect #(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned TOGGLE_US = 35,
  parameter int unsigned GLITCH_US = 5,
  parameter int unsigned SLEEP_US  = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic txd_i,
  output logic en_rise_o,
  output logic toggle_o,
  output logic glitch_o,
  output logic sleep_due_o
);
  localparam int unsigned LOW_MAX = (SLEEP_US > GLITCH_US) ? SLEEP_US : GLITCH_US;
  localparam int unsigned LW      = $clog2(LOW_MAX + 1);
  localparam int unsigned SW      = $clog2(TOGGLE_US + 1);

  logic          en_q, seq_start_q, seq_arm_q, sleep_arm_q;
  logic          en_fall, seq_run;
  logic [LW-1:0] low_us;
  logic [SW-1:0] seq_us;

  assign en_rise_o = en_i & ~en_q;
  assign en_fall   = ~en_i & en_q;
  assign seq_run   = ~en_i & (seq_start_q | ~txd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      seq_start_q <= 1'b0;
      seq_arm_q   <= 1'b0;
      sleep_arm_q <= 1'b0;
    end else begin
      en_q <= en_i;
      if (en_i) begin
        seq_start_q <= 1'b0;
        seq_arm_q   <= 1'b0;
        sleep_arm_q <= 1'b0;
      end else begin
        if (!txd_i)                seq_start_q <= 1'b1;
        if (seq_start_q && txd_i)  seq_arm_q   <= 1'b1;
        if (en_fall)               sleep_arm_q <= txd_i;
      end
    end
  end

  lin_us_timer #(.CLK_HZ(CLK_HZ), .MAX_US(LOW_MAX)) u_low_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(en_i), .run_i(~en_i), .us_o(low_us)
  );

  lin_us_timer #(.CLK_HZ(CLK_HZ), .MAX_US(TOGGLE_US)) u_seq_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(en_i), .run_i(seq_run), .us_o(seq_us)
  );

  assign toggle_o    = en_rise_o & seq_arm_q & txd_i & (seq_us < SW'(TOGGLE_US));
  assign glitch_o    = en_rise_o & (low_us < LW'(GLITCH_US));
  assign sleep_due_o = ~en_i & sleep_arm_q & (low_us >= LW'(SLEEP_US));

  // R7: a fast handshake needs transmit data high at the enable edge
  p_toggle_txd_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_o |-> (txd_i && !$past(en_i)));

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl #(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned TOGGLE_US = 35,
  parameter int unsigned GLITCH_US = 5,
  parameter int unsigned SLEEP_US  = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       wake_i,
  output logic [2:0] mode_o,
  output logic       inh_o,
  output logic       drv_en_o,
  output logic       drv_dom_o,
  output logic [1:0] slew_o,
  output logic       pullup_res_o,
  output logic [1:0] rxd_ctl_o
);
  import lin_mode_pkg::*;

  lin_mode_e state_q, state_d;
  logic      rate_slow_q;
  logic      en_rise, toggle_hit, glitch_hit, sleep_due;
  lin_mode_e base_mode;

  lin_toggle_detect #(
    .CLK_HZ(CLK_HZ), .TOGGLE_US(TOGGLE_US),
    .GLITCH_US(GLITCH_US), .SLEEP_US(SLEEP_US)
  ) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .txd_i(txd_i),
    .en_rise_o(en_rise), .toggle_o(toggle_hit),
    .glitch_o(glitch_hit), .sleep_due_o(sleep_due)
  );

  assign base_mode = rate_slow_q ? M_SLOW : M_NORMAL;

  always_comb begin
    state_d = state_q;
    case (state_q)
      M_SLEEP, M_AWAKE: begin
        if (en_rise)                              state_d = txd_i ? M_NORMAL : M_WAITSLOW;
        else if (wake_i && state_q == M_SLEEP)    state_d = M_AWAKE;
      end
      M_WAITSLOW: if (txd_i) state_d = M_SLOW;
      M_NORMAL, M_SLOW: begin
        if (sleep_due)       state_d = M_SLEEP;
        else if (toggle_hit) state_d = M_FAST;
      end
      M_FAST: begin
        if (sleep_due)                     state_d = M_SLEEP;
        else if (toggle_hit || glitch_hit) state_d = base_mode;
      end
      default: state_d = M_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= M_AWAKE;
      rate_slow_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if ((state_q == M_SLEEP || state_q == M_AWAKE) && en_rise)
        rate_slow_q <= ~txd_i;
    end
  end

  assign mode_o       = state_q;
  assign inh_o        = (state_q != M_SLEEP);
  assign pullup_res_o = (state_q != M_SLEEP);
  assign drv_en_o     = mode_drives(state_q);
  assign drv_dom_o    = drv_en_o & ~txd_i;
  assign slew_o       = mode_slew(state_q);
  assign rxd_ctl_o    = mode_rxd(state_q);

  // R4: no direct crossing between the two locked rates
  p_rate_lock_norm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_NORMAL) |=> (state_q != M_SLOW && state_q != M_WAITSLOW));
  p_rate_lock_slow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_SLOW || state_q == M_WAITSLOW) |=> (state_q != M_NORMAL));

  // R3: transmit data high in Wait Slow completes slow selection
  p_waitslow_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_WAITSLOW && txd_i) |=> (state_q == M_SLOW));

  // R5: sleep entered only while enable is low
  p_sleep_en_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q != M_SLEEP) ##1 (state_q == M_SLEEP)) |-> !$past(en_i));

  // R7: fast only from a driving rate mode
  p_fast_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q != M_FAST) ##1 (state_q == M_FAST)) |->
      ($past(state_q) == M_NORMAL || $past(state_q) == M_SLOW));

  // R8: leaving fast lands on the locked rate or in sleep
  p_fast_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == M_FAST) ##1 (state_q != M_FAST)) |->
      (state_q == M_SLEEP || state_q == base_mode));

  // R11: wake event leaves sleep
  p_wake_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_SLEEP && wake_i && !en_rise) |=> (state_q == M_AWAKE));

  // R6: sleep keeps regulator and driver off
  p_sleep_outputs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_SLEEP) |-> (!inh_o && !drv_en_o && !pullup_res_o));

endmodule

// File: tb/lin_mode_ctrl_tb_top.sv
module lin_mode_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic txd = 1'b1;
  logic wake = 1'b0;

  logic [2:0] mode;
  logic       inh, drv_en, drv_dom, pull;
  logic [1:0] slew, rxd;

  always #5 clk = ~clk;

  lin_mode_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .txd_i(txd), .wake_i(wake),
    .mode_o(mode), .inh_o(inh), .drv_en_o(drv_en), .drv_dom_o(drv_dom),
    .slew_o(slew), .pullup_res_o(pull), .rxd_ctl_o(rxd)
  );

  typedef struct {
    string      tag;
    logic [2:0] mode;
    logic       inh, drv, dom, pull;
    logic [1:0] slew, rxd;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  // bench-side view of the requirement tables
  function automatic exp_t predict(string tag, logic [2:0] m, logic t);
    exp_t e;
    e.tag  = tag;
    e.mode = m;
    e.inh  = (m != 3'd0);
    e.pull = (m != 3'd0);
    e.drv  = (m == 3'd2) || (m == 3'd4) || (m == 3'd5);
    e.dom  = e.drv && !t;
    e.slew = (m == 3'd4 || m == 3'd3) ? 2'd0 : (m == 3'd5) ? 2'd2 : 2'd1;
    case (m)
      3'd0:    e.rxd = 2'd0;
      3'd1:    e.rxd = 2'd1;
      3'd3:    e.rxd = 2'd2;
      default: e.rxd = 2'd3;
    endcase
    return e;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic us(int n);
    cyc(n * 100);
  endtask

  task automatic expect_mode(string tag, logic [2:0] m);
    q.push_back(predict(tag, m, txd));
    cyc(3);
  endtask

  task automatic fast_handshake(int low_us, int high_us);
    en = 1'b0; txd = 1'b0;
    us(low_us);
    txd = 1'b1;
    us(high_us);
    en = 1'b1;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (mode !== e.mode || inh !== e.inh || drv_en !== e.drv || drv_dom !== e.dom ||
            pull !== e.pull || slew !== e.slew || rxd !== e.rxd) begin
          fails++;
          $display("FAIL %s: got mode=%0d inh=%b drv=%b dom=%b pull=%b slew=%0d rxd=%0d expected mode=%0d inh=%b drv=%b dom=%b pull=%b slew=%0d rxd=%0d",
                   e.tag, mode, inh, drv_en, drv_dom, pull, slew, rxd,
                   e.mode, e.inh, e.drv, e.dom, e.pull, e.slew, e.rxd);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got run still active expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    expect_mode("R1 reset state awake", 3'd1);

    txd = 1'b1; cyc(1); en = 1'b1;
    expect_mode("R2 enable rise txd high gives normal", 3'd2);
    txd = 1'b0;
    expect_mode("R9 normal txd low drives dominant", 3'd2);
    txd = 1'b1;
    expect_mode("R9 normal txd high recessive", 3'd2);

    en = 1'b0; us(2); en = 1'b1;
    expect_mode("R10 short enable glitch in normal ignored", 3'd2);
    en = 1'b0; txd = 1'b0; us(10); en = 1'b1;
    expect_mode("R10 long low with txd low ignored", 3'd2);
    txd = 1'b1;

    fast_handshake(40, 1);
    expect_mode("R7 handshake beyond window stays normal", 3'd2);

    fast_handshake(3, 3);
    expect_mode("R7 handshake within window gives fast", 3'd5);
    txd = 1'b0;
    expect_mode("R9 fast drives dominant with fast slew", 3'd5);
    txd = 1'b1;
    en = 1'b0; us(2); en = 1'b1;
    expect_mode("R8 glitch returns fast to normal", 3'd2);

    fast_handshake(3, 3);
    expect_mode("R7 fast again from normal", 3'd5);
    fast_handshake(2, 2);
    expect_mode("R8 repeated handshake returns to normal", 3'd2);

    en = 1'b0; us(30);
    expect_mode("R5 enable low 30us not yet asleep", 3'd2);
    en = 1'b1;
    expect_mode("R5 early return keeps normal", 3'd2);

    en = 1'b0; us(47);
    expect_mode("R5 still normal before sleep delay", 3'd2);
    us(3);
    expect_mode("R6 sleep outputs after delay", 3'd0);

    txd = 1'b0; cyc(2); en = 1'b1;
    expect_mode("R3 wake with txd low gives wait slow", 3'd3);
    txd = 1'b1;
    expect_mode("R3 txd high completes slow", 3'd4);

    en = 1'b0; us(2); en = 1'b1;
    expect_mode("R10 glitch in slow ignored", 3'd4);
    fast_handshake(40, 1);
    expect_mode("R4 slow stays locked after enable cycle", 3'd4);

    fast_handshake(3, 3);
    expect_mode("R7 fast from slow", 3'd5);
    en = 1'b0; us(2); en = 1'b1;
    expect_mode("R8 glitch returns fast to slow", 3'd4);

    en = 1'b0; us(55);
    expect_mode("R5 sleep entered from slow", 3'd0);
    wake = 1'b1; cyc(1); wake = 1'b0;
    expect_mode("R11 wake event gives awake", 3'd1);
    en = 1'b1;
    expect_mode("R2 awake enable rise gives normal", 3'd2);

    cyc(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule